// File: doc/BRIEF.md
# External Bus Cycle Timing Sequencer

This block paces a single access on an external parallel bus, or a burst of several beats, for whichever address window the surrounding logic has already selected. When it accepts a request, it takes a snapshot of that window's timing settings. It then drives an address-valid level and a start strobe. After a programmable number of setup edges it raises the chip-select. Each beat ends either when an internal wait count runs out or when an external acknowledge pin arrives, whichever the settings allow. The chip-select then drops, and the address is held for a programmable time before the block returns to idle.

The surrounding logic keeps two jobs for itself. It decodes which window the address falls in, and it steers byte lanes. It uses `beat_idx` as the offset that moves the address forward from beat to beat. It uses `beat_done` to move data for each beat. `cycle_done` tells it when the bus is free again.

Top module: `ebus_cycle_seq`

## Requirements
- R1: A request (`req_valid` high at a rising edge) is accepted only while `addr_valid` is low. `addr_valid` rises in the next cycle. The direction, the beat count and all timing inputs are captured at acceptance. Changes to them, or further requests, while the access runs have no effect on any output.
- R2: With a 2-bit setup code S (0..3), `chip_sel` rises after the (S+1)th rising edge following the first cycle of `addr_valid`. `addr_valid` is therefore high with `chip_sel` low for exactly S+1 cycles.
- R3: With auto-acknowledge on and no external acknowledge, each beat holds `chip_sel` high for W+1 cycles. W is the 6-bit wait code in use, 0..63.
- R4: `ext_ack` is looked at only while `chip_sel` is high. With auto-acknowledge on, `ext_ack` high in beat cycle j (counting from 0) with j <= W ends the beat after j+1 cycles. With auto-acknowledge off, only `ext_ack` ends a beat.
- R5: When secondary waits are enabled, the beats after the first use the secondary 6-bit wait code. The first beat always uses the primary code, and when secondary waits are disabled every beat uses the primary code.
- R6: After the last beat, `addr_valid` stays high with `chip_sel` low for a hold time H. For a write, H = code+1. For a read, H = code+1 with auto-acknowledge off and H = code with it on. Each hold code is 2 bits.
- R7: Hold time is inserted only after the last beat. Between the beats of a burst, `chip_sel` stays high without a gap.
- R8: With extended start off, `xfer_start` is high for exactly the first cycle of `addr_valid`. With it on, `xfer_start` stays high through the first cycle in which `chip_sel` is high.
- R9: `beat_done` is high for one cycle right after each beat ends. `beat_idx` is 0 for the first beat and increases by one at the end of each beat that is not the last. `req_beats_m1` holds the beat count minus one.
- R10: In the cycle after the hold period ends, `addr_valid` is low and `cycle_done` is high for exactly one cycle. A new request may be accepted in that same cycle.
- R11: After reset, `xfer_start`, `chip_sel`, `addr_valid`, `beat_done`, `cycle_done` and `beat_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start request, taken only while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_beats_m1 | input | BEAT_W | Number of beats minus one |
| cfg_setup | input | 2 | Setup edges before chip-select, code+1 |
| cfg_wait | input | 6 | Primary wait states |
| cfg_sec_en | input | 1 | Use secondary wait count for beats after the first |
| cfg_sec_wait | input | 6 | Secondary wait states |
| cfg_auto_ack | input | 1 | Enable internal acknowledge from the wait count |
| cfg_wr_hold | input | 2 | Write hold code |
| cfg_rd_hold | input | 2 | Read hold code |
| cfg_ext_start | input | 1 | Stretch the start strobe until chip-select is seen |
| ext_ack | input | 1 | External transfer acknowledge |
| xfer_start | output | 1 | Transfer-start strobe |
| chip_sel | output | 1 | Chip-select, active high |
| addr_valid | output | 1 | Address and attributes valid |
| beat_idx | output | BEAT_W | Current beat offset for address advance |
| beat_done | output | 1 | One-cycle pulse after each beat ends |
| cycle_done | output | 1 | One-cycle pulse after the hold period |

## Verification
Two events can fall on the same edge: the external acknowledge and the expiry of the internal wait count. The bench provokes this by raising `ext_ack` in exactly the last wait cycle of a beat with auto-acknowledge on. It then checks that the beat still lasts W+1 cycles and produces a single `beat_done`. The bench also starts a new access in the very cycle that `cycle_done` is high, so that the completion pulse and the next acceptance coincide. It then checks that the new access's setup timing starts cleanly from that edge.

// File: rtl/ebus_seq_pkg.sv
package ebus_seq_pkg;

    localparam int SETUP_W = 2;
    localparam int WAIT_W  = 6;
    localparam int HOLD_W  = 2;
    localparam int CNT_W   = WAIT_W;

    typedef struct packed {
        logic [SETUP_W-1:0] setup;
        logic [WAIT_W-1:0]  wait_n;
        logic               sec_en;
        logic [WAIT_W-1:0]  sec_wait;
        logic               auto_ack;
        logic [HOLD_W-1:0]  wr_hold;
        logic [HOLD_W-1:0]  rd_hold;
        logic               ext_start;
    } bus_timing_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_DATA  = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_t;

    // Number of hold cycles after the last beat.
    function automatic logic [HOLD_W:0] hold_len(
        input logic              is_write,
        input logic              auto_ack,
        input logic [HOLD_W-1:0] wr_code,
        input logic [HOLD_W-1:0] rd_code
    );
        logic [HOLD_W:0] base;
        base = is_write ? {1'b0, wr_code} : {1'b0, rd_code};
        if (is_write || !auto_ack)
            return base + 1'b1;
        return base;
    endfunction

endpackage

// File: rtl/ebus_down_counter.sv
module ebus_down_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (dec && (count_q != '0))
            count_q <= count_q - 1'b1;
    end

    assign zero = (count_q == '0);

    // R3
    wait_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && zero) |=> zero);

endmodule

// File: rtl/ebus_beat_tracker.sv
module ebus_beat_tracker #(
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BEAT_W-1:0] last_in,
    input  logic              advance,
    output logic [BEAT_W-1:0] idx,
    output logic              is_last
);
    logic [BEAT_W-1:0] idx_q;
    logic [BEAT_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            last_q <= '0;
        end else if (start) begin
            idx_q  <= '0;
            last_q <= last_in;
        end else if (advance) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign idx     = idx_q;
    assign is_last = (idx_q == last_q);

    // R9
    beat_adv_bound_chk: assert property (@(posedge clk) disable iff (rst)
        advance |-> !is_last);

endmodule

// File: rtl/ebus_cfg_snapshot.sv
module ebus_cfg_snapshot
    import ebus_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        capture,
    input  bus_timing_t cfg_in,
    input  logic        write_in,
    output bus_timing_t cfg_q,
    output logic        write_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            write_q <= 1'b0;
        end else if (capture) begin
            cfg_q   <= cfg_in;
            write_q <= write_in;
        end
    end
endmodule

// File: rtl/ebus_phase_ctrl.sv
module ebus_phase_ctrl
    import ebus_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [SETUP_W-1:0] live_setup,
    input  bus_timing_t        cfg_q,
    input  logic               write_q,
    input  logic               ext_ack,
    input  logic               cnt_zero,
    input  logic               is_last,
    output logic               accept,
    output logic               cnt_load,
    output logic [CNT_W-1:0]   cnt_val,
    output logic               cnt_dec,
    output logic               beat_adv,
    output logic               ts_q,
    output logic               cs_q,
    output logic               av_q,
    output logic               bd_q,
    output logic               cd_q
);
    seq_state_t      state_q, state_d;
    logic            term;
    logic [HOLD_W:0] hold_n;

    assign term   = (state_q == ST_DATA) && (ext_ack || (cfg_q.auto_ack && cnt_zero));
    assign hold_n = hold_len(write_q, cfg_q.auto_ack, cfg_q.wr_hold, cfg_q.rd_hold);

    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        beat_adv = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    state_d  = ST_SETUP;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(live_setup);
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    state_d  = ST_DATA;
                    cnt_load = 1'b1;
                    cnt_val  = cfg_q.wait_n;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_DATA: begin
                if (term) begin
                    if (is_last) begin
                        if (hold_n == '0) begin
                            state_d = ST_IDLE;
                        end else begin
                            state_d  = ST_HOLD;
                            cnt_load = 1'b1;
                            cnt_val  = CNT_W'(hold_n - 1'b1);
                        end
                    end else begin
                        beat_adv = 1'b1;
                        cnt_load = 1'b1;
                        cnt_val  = cfg_q.sec_en ? cfg_q.sec_wait : cfg_q.wait_n;
                    end
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_zero)
                    state_d = ST_IDLE;
                else
                    cnt_dec = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ts_q    <= 1'b0;
            cs_q    <= 1'b0;
            av_q    <= 1'b0;
            bd_q    <= 1'b0;
            cd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            av_q    <= (state_d != ST_IDLE);
            cs_q    <= (state_d == ST_DATA);
            bd_q    <= term;
            cd_q    <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            if (accept)
                ts_q <= 1'b1;
            else if (cfg_q.ext_start)
                ts_q <= ts_q && !cs_q;
            else
                ts_q <= 1'b0;
        end
    end

    // R1
    start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(av_q) |-> $past(req_valid));

    // R2
    cs_inside_addr_chk: assert property (@(posedge clk) disable iff (rst)
        cs_q |-> av_q);

    // R4
    ext_only_term_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && !cfg_q.auto_ack && !ext_ack) |=> !bd_q);

    // R7
    cs_drop_last_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_q) |-> $past(is_last));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cd_q |-> (!av_q && $past(av_q)));

endmodule

// File: rtl/ebus_cycle_seq.sv
module ebus_cycle_seq
    import ebus_seq_pkg::*;
#(
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BEAT_W-1:0] req_beats_m1,
    input  logic [1:0]        cfg_setup,
    input  logic [5:0]        cfg_wait,
    input  logic              cfg_sec_en,
    input  logic [5:0]        cfg_sec_wait,
    input  logic              cfg_auto_ack,
    input  logic [1:0]        cfg_wr_hold,
    input  logic [1:0]        cfg_rd_hold,
    input  logic              cfg_ext_start,
    input  logic              ext_ack,
    output logic              xfer_start,
    output logic              chip_sel,
    output logic              addr_valid,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              beat_done,
    output logic              cycle_done
);
    bus_timing_t      cfg_live, cfg_q;
    logic             write_q;
    logic             accept, cnt_load, cnt_dec, cnt_zero, beat_adv, is_last;
    logic [CNT_W-1:0] cnt_val;

    always_comb begin
        cfg_live.setup     = cfg_setup;
        cfg_live.wait_n    = cfg_wait;
        cfg_live.sec_en    = cfg_sec_en;
        cfg_live.sec_wait  = cfg_sec_wait;
        cfg_live.auto_ack  = cfg_auto_ack;
        cfg_live.wr_hold   = cfg_wr_hold;
        cfg_live.rd_hold   = cfg_rd_hold;
        cfg_live.ext_start = cfg_ext_start;
    end

    ebus_cfg_snapshot u_cfg (
        .clk      (clk),
        .rst      (rst),
        .capture  (accept),
        .cfg_in   (cfg_live),
        .write_in (req_write),
        .cfg_q    (cfg_q),
        .write_q  (write_q)
    );

    ebus_down_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    ebus_beat_tracker #(.BEAT_W(BEAT_W)) u_beats (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .last_in (req_beats_m1),
        .advance (beat_adv),
        .idx     (beat_idx),
        .is_last (is_last)
    );

    ebus_phase_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .live_setup (cfg_live.setup),
        .cfg_q      (cfg_q),
        .write_q    (write_q),
        .ext_ack    (ext_ack),
        .cnt_zero   (cnt_zero),
        .is_last    (is_last),
        .accept     (accept),
        .cnt_load   (cnt_load),
        .cnt_val    (cnt_val),
        .cnt_dec    (cnt_dec),
        .beat_adv   (beat_adv),
        .ts_q       (xfer_start),
        .cs_q       (chip_sel),
        .av_q       (addr_valid),
        .bd_q       (beat_done),
        .cd_q       (cycle_done)
    );

endmodule

// File: tb/ebus_cycle_seq_tb.sv
module ebus_cycle_seq_tb;
    localparam int BW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [BW-1:0] req_beats_m1 = '0;
    logic [1:0]    cfg_setup = '0, cfg_wr_hold = '0, cfg_rd_hold = '0;
    logic [5:0]    cfg_wait = '0, cfg_sec_wait = '0;
    logic          cfg_sec_en = 1'b0, cfg_auto_ack = 1'b0, cfg_ext_start = 1'b0;
    logic          ext_ack = 1'b0;
    logic          xfer_start, chip_sel, addr_valid, beat_done, cycle_done;
    logic [BW-1:0] beat_idx;

    always #5 clk = ~clk;

    ebus_cycle_seq #(.BEAT_W(BW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_beats_m1(req_beats_m1), .cfg_setup(cfg_setup), .cfg_wait(cfg_wait),
        .cfg_sec_en(cfg_sec_en), .cfg_sec_wait(cfg_sec_wait), .cfg_auto_ack(cfg_auto_ack),
        .cfg_wr_hold(cfg_wr_hold), .cfg_rd_hold(cfg_rd_hold), .cfg_ext_start(cfg_ext_start),
        .ext_ack(ext_ack), .xfer_start(xfer_start), .chip_sel(chip_sel),
        .addr_valid(addr_valid), .beat_idx(beat_idx), .beat_done(beat_done),
        .cycle_done(cycle_done)
    );

    typedef struct {
        bit ts, cs, av, bd, cd, ack;
        int idx;
    } exp_t;

    exp_t  eq[$];
    int    ack_plan[8];
    int    idle_idx = 0;
    int    n_checks = 0, n_fails = 0;
    bit    noise_on = 1'b0;
    bit    finished = 1'b0;
    string ttag = "R11";

    task automatic chk(input int got, input int exp, input string field, input string ftag);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s (%s) %s at %0t: got %0d expected %0d", ttag, ftag, field, $time, got, exp);
        end
    endtask

    task automatic clear_acks();
        for (int i = 0; i < 8; i++) ack_plan[i] = -1;
    endtask

    // One clock: pop the expected vector, compare, drive ext_ack for this cycle.
    task automatic step();
        exp_t e;
        @(negedge clk);
        req_valid = 1'b0;
        if (eq.size() > 0) e = eq.pop_front();
        else begin
            e = '{default: 0};
            e.idx = idle_idx;
        end
        chk(xfer_start, e.ts, "xfer_start", "R8");
        chk(chip_sel,   e.cs, "chip_sel",   "R3");
        chk(addr_valid, e.av, "addr_valid", "R10");
        chk(beat_done,  e.bd, "beat_done",  "R9");
        chk(cycle_done, e.cd, "cycle_done", "R10");
        chk(beat_idx,   e.idx, "beat_idx",  "R9");
        if (e.cd) idle_idx = e.idx;
        ext_ack = e.ack;
        if (noise_on && e.av) begin
            // R1: a request and new settings while busy must change nothing
            req_valid     = 1'b1;
            req_write     = ~req_write;
            req_beats_m1  = req_beats_m1 ^ 3'b101;
            cfg_setup     = cfg_setup ^ 2'b11;
            cfg_wait      = cfg_wait ^ 6'h2a;
            cfg_sec_en    = ~cfg_sec_en;
            cfg_sec_wait  = cfg_sec_wait ^ 6'h15;
            cfg_auto_ack  = ~cfg_auto_ack;
            cfg_wr_hold   = cfg_wr_hold ^ 2'b10;
            cfg_rd_hold   = cfg_rd_hold ^ 2'b01;
            cfg_ext_start = ~cfg_ext_start;
        end
    endtask

    // Build the expected trace from the requirements and present the request.
    task automatic launch(input bit wr, input int beats, input int s, input int w,
                          input bit sec, input int sw, input bit aa,
                          input int wh, input int rh, input bit xs);
        exp_t e;
        bit   pend = 1'b0;
        int   hold;
        while (eq.size() > 0) step();
        for (int i = 0; i <= s; i++) begin
            e = '{default: 0}; e.av = 1;
            eq.push_back(e);
        end
        for (int k = 0; k < beats; k++) begin
            int wk, a, len;
            wk  = (k > 0 && sec) ? sw : w;
            a   = ack_plan[k];
            if (aa) len = (a >= 0 && a <= wk) ? a + 1 : wk + 1;
            else    len = a + 1;
            for (int j = 0; j < len; j++) begin
                e = '{default: 0}; e.av = 1; e.cs = 1; e.idx = k;
                e.ack = (j == a); e.bd = pend; pend = 0;
                eq.push_back(e);
            end
            pend = 1;
        end
        hold = wr ? wh + 1 : (aa ? rh : rh + 1);
        for (int h = 0; h < hold; h++) begin
            e = '{default: 0}; e.av = 1; e.idx = beats - 1; e.bd = pend; pend = 0;
            eq.push_back(e);
        end
        e = '{default: 0}; e.cd = 1; e.idx = beats - 1; e.bd = pend;
        eq.push_back(e);
        for (int c = 0; c < eq.size(); c++)
            eq[c].ts = (c == 0) || (xs && c <= s + 1);
        req_valid     = 1'b1;
        req_write     = wr;
        req_beats_m1  = BW'(beats - 1);
        cfg_setup     = 2'(s);
        cfg_wait      = 6'(w);
        cfg_sec_en    = sec;
        cfg_sec_wait  = 6'(sw);
        cfg_auto_ack  = aa;
        cfg_wr_hold   = 2'(wh);
        cfg_rd_hold   = 2'(rh);
        cfg_ext_start = xs;
    endtask

    task automatic drain();
        while (eq.size() > 0) step();
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        clear_acks();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R11: reset state
        ttag = "R11"; step(); step();

        // R2 / R3: minimal write, setup 0, wait 0, write hold 1 cycle
        ttag = "R2"; clear_acks();
        launch(1, 1, 0, 0, 0, 0, 1, 0, 0, 0); drain();

        // R2 / R6: setup code 3, read with auto ack, read hold code 0 -> no hold
        ttag = "R2"; clear_acks();
        launch(0, 1, 3, 2, 0, 0, 1, 0, 0, 0); drain();

        // R8: extended start strobe
        ttag = "R8"; clear_acks();
        launch(1, 1, 1, 1, 0, 0, 1, 1, 0, 1); drain();
        ttag = "R8"; clear_acks();
        launch(0, 2, 0, 0, 0, 0, 1, 0, 1, 1); drain();

        // R4: early external acknowledge cuts a long wait
        ttag = "R4"; clear_acks(); ack_plan[0] = 3;
        launch(0, 1, 0, 10, 0, 0, 1, 0, 2, 0); drain();

        // R4: no auto ack, only the external acknowledge ends the beat
        ttag = "R4"; clear_acks(); ack_plan[0] = 5;
        launch(0, 1, 1, 0, 0, 0, 0, 0, 1, 0); drain();

        // R4: external acknowledge on the same edge as wait expiry
        ttag = "R4"; clear_acks(); ack_plan[0] = 4;
        launch(1, 1, 0, 4, 0, 0, 1, 1, 0, 0); drain();

        // R5 / R7 / R9: burst of four with secondary waits
        ttag = "R5"; clear_acks();
        launch(1, 4, 1, 3, 1, 1, 1, 2, 0, 0); drain();

        // R5: secondary value ignored when disabled
        ttag = "R5"; clear_acks();
        launch(0, 3, 0, 2, 0, 9, 1, 0, 1, 0); drain();

        // R7 / R4: burst without auto ack, acks at various points
        ttag = "R7"; clear_acks(); ack_plan[0] = 0; ack_plan[1] = 2; ack_plan[2] = 1;
        launch(0, 3, 2, 7, 1, 5, 0, 0, 2, 0); drain();

        // R6: read hold 4 with auto ack off, write hold 4
        ttag = "R6"; clear_acks(); ack_plan[0] = 1;
        launch(0, 1, 0, 0, 0, 0, 0, 0, 3, 0); drain();
        ttag = "R6"; clear_acks();
        launch(1, 1, 0, 0, 0, 0, 1, 3, 0, 0); drain();

        // R3: maximum wait count
        ttag = "R3"; clear_acks();
        launch(1, 1, 0, 63, 0, 0, 1, 0, 0, 0); drain();

        // R1: requests and setting changes while busy are ignored
        ttag = "R1"; clear_acks(); noise_on = 1'b1;
        launch(1, 2, 2, 3, 1, 2, 1, 1, 0, 1);
        while (eq.size() > 0) step();
        noise_on = 1'b0;
        step(); step();

        // R10: back-to-back accesses, new request in the completion cycle
        ttag = "R10"; clear_acks();
        launch(0, 1, 0, 1, 0, 0, 1, 0, 0, 0);
        ttag = "R10"; clear_acks();
        launch(1, 2, 1, 0, 0, 0, 1, 0, 0, 0);
        ttag = "R10"; clear_acks();
        launch(0, 1, 3, 0, 0, 0, 1, 0, 0, 1);
        drain();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule